// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the register side of taking an exception in a 32-bit processor core. A pipeline stage presents either a general exception (cause code, faulting PC, and optionally a faulting virtual address) or a debug exception (its own cause code plus the same PC). The block picks the entry vector class, updates the processor status word and the saved-state registers, and emits a one-cycle redirect pulse together with the chosen vector class. Fetch redirection uses the vector class to select a base address kept elsewhere.

The debug path is gated by priority: a debug request is taken only when the interrupt level presented by the core is strictly below the configured debug level. A general exception raised while the status word already shows exception mode is treated as a double exception. The core can also load the status word through a write port, for example on exception return; an entry taken in the same cycle overrides that write.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low, every register output (status, saved PCs, saved status, both cause registers, faulting address, vector class) reads zero and `redirect_o` is low.
- R2: The status word is laid out as interrupt level in bits [3:0], exception mode in bit 4 and user mode in bit 5. A general exception taken with exception mode clear stores the PC in `epc1_o` and selects vector class 1 (user) when user mode is set, or 0 (kernel) when it is clear.
- R3: A general exception taken with exception mode already set selects vector class 2 (double); with `HAS_DEPC` = 1 the PC goes to `depc_o` and `epc1_o` keeps its value, with `HAS_DEPC` = 0 the PC goes to `epc1_o`.
- R4: Every taken general exception loads `cause_o` from the request and sets the exception-mode bit, leaving the interrupt-level and user-mode fields unchanged.
- R5: `vaddr_o` is loaded from `exc_va_i` only when a taken general exception has `exc_va_vld_i` high; otherwise it holds.
- R6: A debug request is ignored (no redirect, no register change) when `cur_ilvl_i` is greater than or equal to `DBG_LVL`.
- R7: A taken debug request loads `dbg_cause_o`, stores the PC in `dbg_epc_o`, copies the prior status word into `dbg_eps_o`, sets status interrupt level to `DBG_LVL` and exception mode to 1 while keeping user mode, selects vector class 3 (debug), and leaves the general-exception registers untouched.
- R8: When a debug request is taken in the same cycle as a general request, only the debug entry happens; when the debug request is gated off, the general request is taken.
- R9: `redirect_o` is high for exactly the cycle after each clock edge at which an entry is taken, and `vec_o` changes only with a redirect.
- R10: With no entry taken, `st_wr_en_i` loads the status word from `st_wr_data_i`; an entry in the same cycle takes precedence over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req_i | input | 1 | General exception request |
| exc_cause_i | input | CAUSE_W | General exception cause code |
| exc_pc_i | input | XLEN | Faulting PC (used by both paths) |
| exc_va_vld_i | input | 1 | Request carries a faulting address |
| exc_va_i | input | XLEN | Faulting virtual address |
| dbg_req_i | input | 1 | Debug exception request |
| dbg_cause_i | input | DCAUSE_W | Debug cause code |
| cur_ilvl_i | input | 4 | Current interrupt level of the core |
| st_wr_en_i | input | 1 | Status word write enable |
| st_wr_data_i | input | 6 | Status word write data |
| redirect_o | output | 1 | One-cycle fetch redirect pulse |
| vec_o | output | 2 | Vector class: 0 kernel, 1 user, 2 double, 3 debug |
| status_o | output | 6 | Processor status word |
| epc1_o | output | XLEN | Level-1 saved PC |
| depc_o | output | XLEN | Double-exception saved PC (zero when not configured) |
| dbg_epc_o | output | XLEN | Saved PC for the debug level |
| dbg_eps_o | output | 6 | Saved status for the debug level |
| cause_o | output | CAUSE_W | Exception cause register |
| dbg_cause_o | output | DCAUSE_W | Debug cause register |
| vaddr_o | output | XLEN | Faulting virtual address register |

## Verification
The bench drives the gating boundary of the debug path at interrupt levels equal to and one below the debug level; a design comparing with less-or-equal would enter debug at the equal level and corrupt the status word. It raises a second general exception while exception mode is still set, where a design that ignored the mode bit would overwrite the level-1 PC and select a kernel or user vector. Collisions of a debug request with a general request, both accepted and gated off, expose a wrong priority as a changed cause register, and a status write in the same cycle as an entry exposes a write that wins and clears exception mode.

// File: rtl/exc_ent_pkg.sv
package exc_ent_pkg;
  localparam int ILVL_W  = 4;
  localparam int STAT_W  = ILVL_W + 2;
  localparam int ST_EXCM = ILVL_W;
  localparam int ST_UM   = ILVL_W + 1;

  typedef enum logic [1:0] {
    VEC_KERNEL = 2'd0,
    VEC_USER   = 2'd1,
    VEC_DOUBLE = 2'd2,
    VEC_DEBUG  = 2'd3
  } vec_e;
endpackage

// File: rtl/exc_decide.sv
module exc_decide
  import exc_ent_pkg::*;
#(
  parameter int DBG_LVL  = 6,
  parameter bit HAS_DEPC = 1'b1
) (
  input  logic              exc_req,
  input  logic              va_vld,
  input  logic              dbg_req,
  input  logic [ILVL_W-1:0] cur_ilvl,
  input  logic              st_wr_en,
  input  logic [STAT_W-1:0] st_wr_data,
  input  logic [STAT_W-1:0] status_q,
  output logic              take_any,
  output logic [1:0]        vec_nxt,
  output logic              status_en,
  output logic [STAT_W-1:0] status_nxt,
  output logic              epc1_en,
  output logic              depc_en,
  output logic              dbg_save_en,
  output logic              cause_en,
  output logic              va_en
);
  localparam logic [ILVL_W-1:0] DBG_LVL_V = ILVL_W'(DBG_LVL);

  logic dbg_ok, take_dbg, take_exc, in_excm;

  always_comb begin
    dbg_ok   = dbg_req && (cur_ilvl < DBG_LVL_V);
    take_dbg = dbg_ok;
    take_exc = exc_req && !dbg_ok;
    in_excm  = status_q[ST_EXCM];
    take_any = take_dbg || take_exc;

    vec_nxt     = VEC_KERNEL;
    status_en   = 1'b0;
    status_nxt  = status_q;
    epc1_en     = 1'b0;
    depc_en     = 1'b0;
    dbg_save_en = 1'b0;
    cause_en    = 1'b0;
    va_en       = 1'b0;

    if (take_dbg) begin
      vec_nxt     = VEC_DEBUG;
      dbg_save_en = 1'b1;
      status_en   = 1'b1;
      status_nxt  = {status_q[ST_UM], 1'b1, DBG_LVL_V};
    end else if (take_exc) begin
      cause_en   = 1'b1;
      va_en      = va_vld;
      status_en  = 1'b1;
      status_nxt = status_q | (STAT_W'(1) << ST_EXCM);
      if (in_excm) begin
        vec_nxt = VEC_DOUBLE;
        depc_en = HAS_DEPC;
        epc1_en = !HAS_DEPC;
      end else begin
        vec_nxt = status_q[ST_UM] ? VEC_USER : VEC_KERNEL;
        epc1_en = 1'b1;
      end
    end else if (st_wr_en) begin
      status_en  = 1'b1;
      status_nxt = st_wr_data;
    end
  end
endmodule

// File: rtl/exc_sr_bank.sv
module exc_sr_bank
  import exc_ent_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int CAUSE_W  = 6,
  parameter int DCAUSE_W = 6,
  parameter bit HAS_DEPC = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [XLEN-1:0]     pc,
  input  logic [XLEN-1:0]     va,
  input  logic [CAUSE_W-1:0]  cause,
  input  logic [DCAUSE_W-1:0] dcause,
  input  logic                take_any,
  input  logic [1:0]          vec_nxt,
  input  logic                status_en,
  input  logic [STAT_W-1:0]   status_nxt,
  input  logic                epc1_en,
  input  logic                depc_en,
  input  logic                dbg_save_en,
  input  logic                cause_en,
  input  logic                va_en,
  output logic                redirect_q,
  output logic [1:0]          vec_q,
  output logic [STAT_W-1:0]   status_q,
  output logic [XLEN-1:0]     epc1_q,
  output logic [XLEN-1:0]     depc_q,
  output logic [XLEN-1:0]     dbg_epc_q,
  output logic [STAT_W-1:0]   dbg_eps_q,
  output logic [CAUSE_W-1:0]  cause_q,
  output logic [DCAUSE_W-1:0] dcause_q,
  output logic [XLEN-1:0]     va_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_q <= 1'b0;
      vec_q      <= '0;
      status_q   <= '0;
    end else begin
      redirect_q <= take_any;
      if (take_any)  vec_q    <= vec_nxt;
      if (status_en) status_q <= status_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc1_q  <= '0;
      cause_q <= '0;
      va_q    <= '0;
    end else begin
      if (epc1_en)  epc1_q  <= pc;
      if (cause_en) cause_q <= cause;
      if (va_en)    va_q    <= va;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_epc_q <= '0;
      dbg_eps_q <= '0;
      dcause_q  <= '0;
    end else if (dbg_save_en) begin
      dbg_epc_q <= pc;
      dbg_eps_q <= status_q;
      dcause_q  <= dcause;
    end
  end

  generate
    if (HAS_DEPC) begin : g_depc
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       depc_q <= '0;
        else if (depc_en) depc_q <= pc;
      end
    end else begin : g_no_depc
      assign depc_q = '0;
    end
  endgenerate
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_ent_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int CAUSE_W  = 6,
  parameter int DCAUSE_W = 6,
  parameter int DBG_LVL  = 6,
  parameter bit HAS_DEPC = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                exc_req_i,
  input  logic [CAUSE_W-1:0]  exc_cause_i,
  input  logic [XLEN-1:0]     exc_pc_i,
  input  logic                exc_va_vld_i,
  input  logic [XLEN-1:0]     exc_va_i,
  input  logic                dbg_req_i,
  input  logic [DCAUSE_W-1:0] dbg_cause_i,
  input  logic [3:0]          cur_ilvl_i,
  input  logic                st_wr_en_i,
  input  logic [5:0]          st_wr_data_i,
  output logic                redirect_o,
  output logic [1:0]          vec_o,
  output logic [5:0]          status_o,
  output logic [XLEN-1:0]     epc1_o,
  output logic [XLEN-1:0]     depc_o,
  output logic [XLEN-1:0]     dbg_epc_o,
  output logic [5:0]          dbg_eps_o,
  output logic [CAUSE_W-1:0]  cause_o,
  output logic [DCAUSE_W-1:0] dbg_cause_o,
  output logic [XLEN-1:0]     vaddr_o
);
  logic              take_any, status_en, epc1_en, depc_en;
  logic              dbg_save_en, cause_en, va_en;
  logic [1:0]        vec_nxt;
  logic [STAT_W-1:0] status_nxt;

  exc_decide #(.DBG_LVL(DBG_LVL), .HAS_DEPC(HAS_DEPC)) u_decide (
    .exc_req     (exc_req_i),
    .va_vld      (exc_va_vld_i),
    .dbg_req     (dbg_req_i),
    .cur_ilvl    (cur_ilvl_i),
    .st_wr_en    (st_wr_en_i),
    .st_wr_data  (st_wr_data_i),
    .status_q    (status_o),
    .take_any    (take_any),
    .vec_nxt     (vec_nxt),
    .status_en   (status_en),
    .status_nxt  (status_nxt),
    .epc1_en     (epc1_en),
    .depc_en     (depc_en),
    .dbg_save_en (dbg_save_en),
    .cause_en    (cause_en),
    .va_en       (va_en)
  );

  exc_sr_bank #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .DCAUSE_W(DCAUSE_W), .HAS_DEPC(HAS_DEPC)
  ) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .pc          (exc_pc_i),
    .va          (exc_va_i),
    .cause       (exc_cause_i),
    .dcause      (dbg_cause_i),
    .take_any    (take_any),
    .vec_nxt     (vec_nxt),
    .status_en   (status_en),
    .status_nxt  (status_nxt),
    .epc1_en     (epc1_en),
    .depc_en     (depc_en),
    .dbg_save_en (dbg_save_en),
    .cause_en    (cause_en),
    .va_en       (va_en),
    .redirect_q  (redirect_o),
    .vec_q       (vec_o),
    .status_q    (status_o),
    .epc1_q      (epc1_o),
    .depc_q      (depc_o),
    .dbg_epc_q   (dbg_epc_o),
    .dbg_eps_q   (dbg_eps_o),
    .cause_q     (cause_o),
    .dcause_q    (dbg_cause_o),
    .va_q        (vaddr_o)
  );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN     = 32,
  parameter int CAUSE_W  = 6,
  parameter int DCAUSE_W = 6,
  parameter int DBG_LVL  = 6,
  parameter bit HAS_DEPC = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                exc_req_i,
  input logic [CAUSE_W-1:0]  exc_cause_i,
  input logic [XLEN-1:0]     exc_pc_i,
  input logic                exc_va_vld_i,
  input logic [XLEN-1:0]     exc_va_i,
  input logic                dbg_req_i,
  input logic [DCAUSE_W-1:0] dbg_cause_i,
  input logic [3:0]          cur_ilvl_i,
  input logic                st_wr_en_i,
  input logic [5:0]          st_wr_data_i,
  input logic                redirect_o,
  input logic [1:0]          vec_o,
  input logic [5:0]          status_o,
  input logic [XLEN-1:0]     epc1_o,
  input logic [XLEN-1:0]     depc_o,
  input logic [XLEN-1:0]     dbg_epc_o,
  input logic [5:0]          dbg_eps_o,
  input logic [CAUSE_W-1:0]  cause_o,
  input logic [DCAUSE_W-1:0] dbg_cause_o,
  input logic [XLEN-1:0]     vaddr_o
);
  // R9: a redirect only follows a request
  p_redirect_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> $past(exc_req_i || dbg_req_i));

  // R9: vector class moves only with a redirect
  p_vec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_o |-> $stable(vec_o));

  // R4: every entry leaves exception mode set
  p_excm_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> status_o[4]);

  // R6: gated-off debug alone changes nothing
  p_dbg_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req_i && cur_ilvl_i >= 4'(DBG_LVL) && !exc_req_i && !st_wr_en_i)
      |=> !redirect_o && $stable(status_o) && $stable(dbg_cause_o));

  // R7: debug entry raises interrupt level to the debug level
  p_dbg_lvl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && vec_o == 2'd3) |-> status_o[3:0] == 4'(DBG_LVL));

  // R3: a double vector only when exception mode was already set
  p_double_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && vec_o == 2'd2) |-> $past(status_o[4]));

  // R3: with a separate double PC, the level-1 PC holds
  p_double_epc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_DEPC && redirect_o && vec_o == 2'd2) |-> $stable(epc1_o));
endmodule

bind exc_entry_ctrl exc_entry_chk #(
  .XLEN(XLEN), .CAUSE_W(CAUSE_W), .DCAUSE_W(DCAUSE_W),
  .DBG_LVL(DBG_LVL), .HAS_DEPC(HAS_DEPC)
) u_chk (.*);

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;
  localparam int XLEN = 32, CW = 6, DW = 6, DBG = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic exc_req = 0, va_vld = 0, dbg_req = 0, st_wr = 0;
  logic [CW-1:0] cause = '0;
  logic [DW-1:0] dcause = '0;
  logic [XLEN-1:0] pc = '0, va = '0;
  logic [3:0] ilvl = '0;
  logic [5:0] st_data = '0;

  logic redirect; logic [1:0] vec; logic [5:0] status, eps;
  logic [XLEN-1:0] epc1, depc, depc_dbg, vaddr;
  logic [CW-1:0] cause_q; logic [DW-1:0] dcause_q;

  exc_entry_ctrl #(.XLEN(XLEN), .CAUSE_W(CW), .DCAUSE_W(DW), .DBG_LVL(DBG), .HAS_DEPC(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req), .exc_cause_i(cause), .exc_pc_i(pc),
    .exc_va_vld_i(va_vld), .exc_va_i(va), .dbg_req_i(dbg_req), .dbg_cause_i(dcause),
    .cur_ilvl_i(ilvl), .st_wr_en_i(st_wr), .st_wr_data_i(st_data),
    .redirect_o(redirect), .vec_o(vec), .status_o(status), .epc1_o(epc1), .depc_o(depc),
    .dbg_epc_o(depc_dbg), .dbg_eps_o(eps), .cause_o(cause_q), .dbg_cause_o(dcause_q),
    .vaddr_o(vaddr));

  always #2 clk = ~clk;  // 250 MHz

  int tests = 0, fails = 0, cycles = 0;
  string tag = "R1";

  // behavioural reference
  int m_redir, m_vec, m_st, m_epc1, m_depc, m_depd, m_eps, m_cause, m_dcause, m_va;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_redir = 0; m_vec = 0; m_st = 0; m_epc1 = 0; m_depc = 0;
      m_depd = 0; m_eps = 0; m_cause = 0; m_dcause = 0; m_va = 0;
    end else begin
      bit excm, um;
      excm = m_st[4]; um = m_st[5];
      if (dbg_req && int'(ilvl) < DBG) begin
        m_dcause = dcause; m_depd = pc; m_eps = m_st;
        m_st = (um ? 32 : 0) + 16 + DBG; m_vec = 3; m_redir = 1;
      end else if (exc_req) begin
        if (va_vld) m_va = va;
        if (excm) begin m_depc = pc; m_vec = 2; end
        else begin m_epc1 = pc; m_vec = um ? 1 : 0; end
        m_cause = cause; m_st = m_st | 16; m_redir = 1;
      end else begin
        m_redir = 0;
        if (st_wr) m_st = st_data;
      end
    end
  end

  task automatic chk(string what, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("redirect", redirect, m_redir);
    chk("vec", vec, m_vec);
    chk("status", status, m_st);
    chk("epc1", epc1, longint'(unsigned'(m_epc1)));
    chk("depc", depc, longint'(unsigned'(m_depc)));
    chk("dbg_epc", depc_dbg, longint'(unsigned'(m_depd)));
    chk("dbg_eps", eps, m_eps);
    chk("cause", cause_q, m_cause);
    chk("dbg_cause", dcause_q, m_dcause);
    chk("vaddr", vaddr, longint'(unsigned'(m_va)));
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    exc_req = 0; dbg_req = 0; st_wr = 0; va_vld = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    tag = "R1";
    repeat (2) @(negedge clk);
    compare_all();
    chk("reset status explicit", status, 0);
    rst_n = 1;
    cyc();

    // R2 kernel entry
    tag = "R2";
    exc_req = 1; cause = 6'd5; pc = 32'h0000_1000; cyc(); idle();
    chk("kernel vec", vec, 0);
    chk("epc1", epc1, 32'h1000);
    tag = "R9"; cyc(); chk("redirect drop", redirect, 0);

    // R10 status write clears exception mode, sets user mode
    tag = "R10";
    st_wr = 1; st_data = 6'h23; cyc(); idle();
    chk("status written", status, 6'h23);

    // R2 user entry, R4 level field preserved, R5 address captured
    tag = "R2";
    exc_req = 1; cause = 6'd9; pc = 32'h0000_2004; va_vld = 1; va = 32'hdead_beef; cyc(); idle();
    chk("user vec", vec, 1);
    tag = "R4"; chk("status excm set, fields kept", status, 6'h33);
    tag = "R5"; chk("vaddr", vaddr, 32'hdead_beef);

    // R3 double exception, R5 address held without flag
    tag = "R3";
    exc_req = 1; cause = 6'd12; pc = 32'h0000_3008; va = 32'h1111_2222; cyc(); idle();
    chk("double vec", vec, 2);
    chk("depc", depc, 32'h3008);
    chk("epc1 held", epc1, 32'h2004);
    tag = "R5"; chk("vaddr held", vaddr, 32'hdead_beef);

    // R6 debug gated at equal and higher levels
    tag = "R6";
    dbg_req = 1; dcause = 6'd3; pc = 32'h4000; ilvl = 4'd6; cyc();
    chk("no redirect at equal level", redirect, 0);
    ilvl = 4'd9; cyc(); idle();
    chk("dbg cause untouched", dcause_q, 0);

    // R7 debug taken one level below
    tag = "R7";
    st_wr = 1; st_data = 6'h21; cyc(); idle();
    dbg_req = 1; dcause = 6'd7; pc = 32'h5000; ilvl = 4'd5; cyc(); idle();
    chk("debug vec", vec, 3);
    chk("eps copy", eps, 6'h21);
    chk("status", status, 6'h36);

    // R8 collision: debug taken wins
    tag = "R8";
    st_wr = 1; st_data = 6'h00; cyc(); idle();
    dbg_req = 1; exc_req = 1; ilvl = 4'd0; dcause = 6'd2; cause = 6'd33; pc = 32'h6000; cyc(); idle();
    chk("debug wins", vec, 3);
    chk("cause kept", cause_q, 12);
    // R8 collision: debug gated, general taken
    st_wr = 1; st_data = 6'h00; cyc(); idle();
    dbg_req = 1; exc_req = 1; ilvl = 4'd7; cause = 6'd40; pc = 32'h7000; cyc(); idle();
    chk("general taken", vec, 0);
    chk("cause", cause_q, 40);

    // R10 entry beats a same-cycle write; R9 back-to-back redirects
    tag = "R10";
    st_wr = 1; st_data = 6'h00; exc_req = 1; cause = 6'd1; pc = 32'h8000; cyc();
    chk("write overridden", status[4], 1);
    tag = "R9";
    st_wr = 0; pc = 32'h8004; cyc(); idle();
    chk("second redirect", redirect, 1);
    cyc();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule